// File: doc/BRIEF.md
# Blitter Mode Decoder and Launch Controller

This block sits in front of a block-transfer engine and decides whether, and how, a transfer is started. Software writes a control byte through a register write port. The block keeps the last written value, so it can detect two edges. Releasing the reset bit (1 to 0) resets the blitter. Raising the start bit (0 to 1) asks for a transfer. When both edges occur in one write, only the reset is acted on.

On a start request, the block reads three static bytes: the mode byte, the extended-mode byte and the raster-operation code. It decodes them into the following:
- an operation class
- a bytes-per-pixel value
- which colour registers the engine must load
- the copy direction, with signed source and destination pitches
- a data path
- a compact raster-operation index

A legal request captures these fields and fires a one-cycle launch strobe. A busy flag then stays high until the engine reports completion. An illegal request is silently turned into a one-cycle blitter-reset strobe, and the decoded fields are cleared.

Top module: `blit_launch_ctl`

## Requirements
- R1: A control write that takes bit 2 from 1 to 0 produces a one-cycle `blitReset` strobe in the cycle after the write, clears `busy`, and zeroes every decoded output field.
- R2: A control write that takes bit 0 from 0 to 1 starts a decode, and the result appears in the cycle after the write. If the same write also releases bit 2, only the reset of R1 takes place and `launch` stays low.
- R3: The width code in extended-mode bits [6:4] gives bytes per pixel as follows: code 0 gives 1, code 1 gives 2, code 2 gives 3, code 3 gives 4. Codes 4 to 7 abort the request, which means `blitReset` pulses, `launch` stays low and the fields are zeroed.
- R4: If mode bit 2 (source in system memory) and mode bit 1 (destination in system memory) are both set, the request is aborted.
- R5: Solid fill (class 0) is selected when extended bit 2 is set and, of mode bits {1, 3 transparent, 6 pattern, 7 colour expand}, exactly bits 6 and 7 are set. Solid fill loads the foreground colour only, uses path 0, and needs no pitch check.
- R6: Colour expand without pattern is class 1. In transparent mode it loads only one colour: the background if extended bit 1 (invert) is set, otherwise the foreground. In opaque mode it loads both colours.
- R7: Pattern with colour expand is class 2 and follows the colour rules of R6. Pattern without colour expand is class 3 (pattern fill) and loads no colour.
- R8: A plain copy (class 4, neither bit 6 nor bit 7) with mode bit 0 set raises `backward` and outputs the negated source and destination pitches. In every other case, `backward` is low and the pitches pass through unchanged.
- R9: Outside solid fill, the path code is 1 (CPU to video) when mode bit 2 is set, 2 (video to CPU) when only mode bit 1 is set, and 0 (video to video) otherwise. Path setup fails, and the request aborts, when a pitch the path needs is zero: the destination pitch for path 1, the source pitch for path 2, both pitches for path 0.
- R10: The raster-operation code maps to an index as follows: 0x00 to 0, 0x05 to 1, 0x0D to 2, 0x50 to 3, 0x59 to 4, 0x6D to 5, 0x90 to 6, 0xD0 to 7. Any other code aborts the request.
- R11: `launch` lasts exactly one cycle. `busy` rises with it and stays high until `engineDone` is seen or a blitter reset occurs.
- R12: A control write with no qualifying edge, or no write at all, produces no strobe and leaves `busy` and the decoded fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 8 | Control byte (bit 0 start, bit 2 reset) |
| modeByte | input | 8 | Mode byte |
| extModeByte | input | 8 | Extended-mode byte |
| ropByte | input | 8 | Raster-operation code |
| srcPitchIn | input | PITCH_W | Source pitch as programmed |
| dstPitchIn | input | PITCH_W | Destination pitch as programmed |
| engineDone | input | 1 | Engine completion pulse |
| launch | output | 1 | One-cycle start strobe to the engine |
| blitReset | output | 1 | One-cycle blitter reset strobe |
| busy | output | 1 | Transfer in progress |
| opClass | output | 3 | Operation class (0 solid, 1 expand, 2 pattern expand, 3 pattern fill, 4 copy) |
| bytesPerPix | output | 3 | Bytes per pixel, 0 when cleared |
| loadFg | output | 1 | Engine loads foreground colour |
| loadBg | output | 1 | Engine loads background colour |
| backward | output | 1 | Backward copy direction |
| dataPath | output | 2 | Path code from R9 |
| ropIndex | output | 3 | Raster-operation index |
| srcPitch | output | PITCH_W | Signed source pitch |
| dstPitch | output | PITCH_W | Signed destination pitch |

## Verification
The assertions assume that the mode, extended-mode, raster-operation and pitch inputs hold steady during the cycle in which a start edge is written. They also assume that `engineDone` is only a completion notice and is never treated as a request. The stimulus drives every static byte and pitch one cycle before the control write. It pulses `engineDone` only after a launch has been observed. For the corner cases it steps the control register through sequences that isolate each edge: start held high, reset bit held high, both edges together, and an undriven write strobe.

// File: rtl/blit_pkg.sv
package blit_pkg;

  // control byte bits
  localparam int CTL_GO  = 0;
  localparam int CTL_RST = 2;

  // mode byte bits
  localparam int MD_BACK   = 0;
  localparam int MD_SYSDST = 1;
  localparam int MD_SYSSRC = 2;
  localparam int MD_TRANSP = 3;
  localparam int MD_PAT    = 6;
  localparam int MD_EXP    = 7;

  // extended-mode byte bits
  localparam int EX_INV    = 1;
  localparam int EX_SOLID  = 2;
  localparam int EX_WLO    = 4;
  localparam int EX_WHI    = 6;

  localparam int ROP_IDX_W = 3;
  localparam int BPP_W     = 3;

  typedef enum logic [2:0] {
    OP_SOLID      = 3'd0,
    OP_EXPAND     = 3'd1,
    OP_PAT_EXPAND = 3'd2,
    OP_PAT_FILL   = 3'd3,
    OP_COPY       = 3'd4
  } opClassT;

  typedef enum logic [1:0] {
    PATH_V2V = 2'd0,
    PATH_C2V = 2'd1,
    PATH_V2C = 2'd2
  } pathT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } stepT;

  // returns {hit, index}
  function automatic logic [ROP_IDX_W:0] ropLookup(input logic [7:0] code);
    case (code)
      8'h00:   ropLookup = {1'b1, 3'd0};
      8'h05:   ropLookup = {1'b1, 3'd1};
      8'h0D:   ropLookup = {1'b1, 3'd2};
      8'h50:   ropLookup = {1'b1, 3'd3};
      8'h59:   ropLookup = {1'b1, 3'd4};
      8'h6D:   ropLookup = {1'b1, 3'd5};
      8'h90:   ropLookup = {1'b1, 3'd6};
      8'hD0:   ropLookup = {1'b1, 3'd7};
      default: ropLookup = '0;
    endcase
  endfunction

endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  input  logic       decodeOk,
  input  logic       engineDone,
  output stepT       step,
  output logic       launch,
  output logic       blitReset,
  output logic       busy
);

  logic [7:0] ctlQ;
  logic       resetEdge;
  logic       startEdge;

  assign resetEdge = ctlWrEn &&  ctlQ[CTL_RST] && !ctlWrData[CTL_RST];
  assign startEdge = ctlWrEn && !ctlQ[CTL_GO]  &&  ctlWrData[CTL_GO];

  // reset edge wins over start edge
  always_comb begin
    step.clear   = resetEdge || (startEdge && !decodeOk);
    step.capture = startEdge && !resetEdge && decodeOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ      <= '0;
      launch    <= 1'b0;
      blitReset <= 1'b0;
      busy      <= 1'b0;
    end else begin
      if (ctlWrEn) ctlQ <= ctlWrData;
      launch    <= step.capture;
      blitReset <= step.clear;
      if (step.clear)        busy <= 1'b0;
      else if (step.capture) busy <= 1'b1;
      else if (engineDone)   busy <= 1'b0;
    end
  end

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(launch && blitReset));

  a_r11_launch_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !launch);

  a_r11_busy_with_launch: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> busy);

  a_r1_reset_drops_busy: assert property (@(posedge clk) disable iff (!rstN)
    blitReset |-> !busy);

  a_r12_no_write_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrEn |=> (!launch && !blitReset));

endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int PITCH_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  stepT                      step,
  input  logic [7:0]                modeByte,
  input  logic [7:0]                extModeByte,
  input  logic [7:0]                ropByte,
  input  logic [PITCH_W-1:0]        srcPitchIn,
  input  logic [PITCH_W-1:0]        dstPitchIn,
  output logic                      decodeOk,
  output opClassT                   opClassQ,
  output logic [BPP_W-1:0]          bppQ,
  output logic                      loadFgQ,
  output logic                      loadBgQ,
  output logic                      backwardQ,
  output pathT                      pathQ,
  output logic [ROP_IDX_W-1:0]      ropIdxQ,
  output logic signed [PITCH_W-1:0] srcPitchQ,
  output logic signed [PITCH_W-1:0] dstPitchQ
);

  localparam int WCODE_W = EX_WHI - EX_WLO + 1;

  logic [WCODE_W-1:0]         widthCode;
  logic                       widthOk;
  logic                       memToMem;
  logic                       isSolid;
  logic                       ropHit;
  logic [ROP_IDX_W-1:0]       ropIdx;
  logic                       pathOk;
  opClassT                    opClassD;
  logic [BPP_W-1:0]           bppD;
  logic                       fgD, bgD, backD;
  pathT                       pathD;
  logic signed [PITCH_W-1:0]  srcD, dstD;

  assign widthCode       = extModeByte[EX_WHI:EX_WLO];
  assign widthOk         = (widthCode < WCODE_W'(4));
  assign memToMem        = modeByte[MD_SYSSRC] && modeByte[MD_SYSDST];
  assign {ropHit, ropIdx} = ropLookup(ropByte);
  assign isSolid = extModeByte[EX_SOLID] &&
                   ({modeByte[MD_SYSDST], modeByte[MD_TRANSP],
                     modeByte[MD_PAT], modeByte[MD_EXP]} == 4'b0011);

  always_comb begin
    bppD     = BPP_W'(widthCode[1:0]) + BPP_W'(1);
    fgD      = 1'b0;
    bgD      = 1'b0;
    backD    = 1'b0;
    srcD     = srcPitchIn;
    dstD     = dstPitchIn;
    pathD    = PATH_V2V;
    pathOk   = 1'b1;
    opClassD = OP_COPY;
    if (isSolid) begin
      opClassD = OP_SOLID;
      fgD      = 1'b1;
    end else begin
      if (modeByte[MD_EXP] || modeByte[MD_PAT]) begin
        if (!modeByte[MD_EXP])      opClassD = OP_PAT_FILL;
        else if (modeByte[MD_PAT])  opClassD = OP_PAT_EXPAND;
        else                        opClassD = OP_EXPAND;
        if (modeByte[MD_EXP]) begin
          if (modeByte[MD_TRANSP]) begin
            bgD = extModeByte[EX_INV];
            fgD = !extModeByte[EX_INV];
          end else begin
            fgD = 1'b1;
            bgD = 1'b1;
          end
        end
      end else if (modeByte[MD_BACK]) begin
        backD = 1'b1;
        srcD  = -$signed(srcPitchIn);
        dstD  = -$signed(dstPitchIn);
      end
      if (modeByte[MD_SYSSRC]) begin
        pathD  = PATH_C2V;
        pathOk = (dstPitchIn != '0);
      end else if (modeByte[MD_SYSDST]) begin
        pathD  = PATH_V2C;
        pathOk = (srcPitchIn != '0);
      end else begin
        pathOk = (srcPitchIn != '0) && (dstPitchIn != '0);
      end
    end
  end

  assign decodeOk = widthOk && !memToMem && ropHit && pathOk;

  always_ff @(posedge clk) begin
    if (!rstN || step.clear) begin
      opClassQ  <= OP_SOLID;
      bppQ      <= '0;
      loadFgQ   <= 1'b0;
      loadBgQ   <= 1'b0;
      backwardQ <= 1'b0;
      pathQ     <= PATH_V2V;
      ropIdxQ   <= '0;
      srcPitchQ <= '0;
      dstPitchQ <= '0;
    end else if (step.capture) begin
      opClassQ  <= opClassD;
      bppQ      <= bppD;
      loadFgQ   <= fgD;
      loadBgQ   <= bgD;
      backwardQ <= backD;
      pathQ     <= pathD;
      ropIdxQ   <= ropIdx;
      srcPitchQ <= srcD;
      dstPitchQ <= dstD;
    end
  end

  a_r8_backward_only_copy: assert property (@(posedge clk) disable iff (!rstN)
    backwardQ |-> (opClassQ == OP_COPY));

  a_r5_solid_fg_only: assert property (@(posedge clk) disable iff (!rstN)
    (opClassQ == OP_SOLID && bppQ != '0) |-> (loadFgQ && !loadBgQ && pathQ == PATH_V2V));

  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    step.clear |=> (bppQ == '0 && srcPitchQ == '0 && dstPitchQ == '0));

  a_r7_fill_no_colour: assert property (@(posedge clk) disable iff (!rstN)
    (opClassQ == OP_PAT_FILL) |-> (!loadFgQ && !loadBgQ));

  a_r12_hold_fields: assert property (@(posedge clk) disable iff (!rstN)
    (!step.capture && !step.clear) |=> ($stable(bppQ) && $stable(opClassQ) && $stable(dstPitchQ)));

endmodule

// File: rtl/blit_launch_ctl.sv
module blit_launch_ctl
  import blit_pkg::*;
#(
  parameter int PITCH_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      ctlWrEn,
  input  logic [7:0]                ctlWrData,
  input  logic [7:0]                modeByte,
  input  logic [7:0]                extModeByte,
  input  logic [7:0]                ropByte,
  input  logic [PITCH_W-1:0]        srcPitchIn,
  input  logic [PITCH_W-1:0]        dstPitchIn,
  input  logic                      engineDone,
  output logic                      launch,
  output logic                      blitReset,
  output logic                      busy,
  output logic [2:0]                opClass,
  output logic [2:0]                bytesPerPix,
  output logic                      loadFg,
  output logic                      loadBg,
  output logic                      backward,
  output logic [1:0]                dataPath,
  output logic [2:0]                ropIndex,
  output logic signed [PITCH_W-1:0] srcPitch,
  output logic signed [PITCH_W-1:0] dstPitch
);

  stepT    step;
  logic    decodeOk;
  opClassT opClassQ;
  pathT    pathQ;

  blit_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctlWrEn    (ctlWrEn),
    .ctlWrData  (ctlWrData),
    .decodeOk   (decodeOk),
    .engineDone (engineDone),
    .step       (step),
    .launch     (launch),
    .blitReset  (blitReset),
    .busy       (busy)
  );

  blit_datapath #(.PITCH_W(PITCH_W)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .step        (step),
    .modeByte    (modeByte),
    .extModeByte (extModeByte),
    .ropByte     (ropByte),
    .srcPitchIn  (srcPitchIn),
    .dstPitchIn  (dstPitchIn),
    .decodeOk    (decodeOk),
    .opClassQ    (opClassQ),
    .bppQ        (bytesPerPix),
    .loadFgQ     (loadFg),
    .loadBgQ     (loadBg),
    .backwardQ   (backward),
    .pathQ       (pathQ),
    .ropIdxQ     (ropIndex),
    .srcPitchQ   (srcPitch),
    .dstPitchQ   (dstPitch)
  );

  assign opClass  = opClassQ;
  assign dataPath = pathQ;

endmodule

// File: tb/test_blit_launch_ctl.sv
`timescale 1ns/1ps
module test_blit_launch_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [7:0]  ctlWrData = '0;
  logic [7:0]  modeByte = '0, extModeByte = '0, ropByte = '0;
  logic [15:0] srcPitchIn = '0, dstPitchIn = '0;
  logic        engineDone = 1'b0;
  logic        launch, blitReset, busy, loadFg, loadBg, backward;
  logic [2:0]  opClass, bytesPerPix, ropIndex;
  logic [1:0]  dataPath;
  logic signed [15:0] srcPitch, dstPitch;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  blit_launch_ctl i_blit_launch_ctl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .modeByte(modeByte), .extModeByte(extModeByte), .ropByte(ropByte),
    .srcPitchIn(srcPitchIn), .dstPitchIn(dstPitchIn), .engineDone(engineDone),
    .launch(launch), .blitReset(blitReset), .busy(busy), .opClass(opClass),
    .bytesPerPix(bytesPerPix), .loadFg(loadFg), .loadBg(loadBg),
    .backward(backward), .dataPath(dataPath), .ropIndex(ropIndex),
    .srcPitch(srcPitch), .dstPitch(dstPitch)
  );

  typedef struct packed {
    logic [7:0]  mode;
    logic [7:0]  ext;
    logic [7:0]  rop;
    logic [15:0] sp;
    logic [15:0] dp;
    logic        ok;
    logic [2:0]  op;
    logic [2:0]  bpp;
    logic        fg;
    logic        bg;
    logic        back;
    logic [1:0]  path;
    logic [2:0]  idx;
  } vecT;

  localparam int NV = 17;
  localparam vecT VEC [NV] = '{
    '{8'h00, 8'h00, 8'h0D, 16'h0040, 16'h0080, 1'b1, 3'd4, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0, 3'd2},
    '{8'h01, 8'h10, 8'h00, 16'h0040, 16'h0080, 1'b1, 3'd4, 3'd2, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0},
    '{8'hC0, 8'h24, 8'h50, 16'h0010, 16'h0020, 1'b1, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0, 2'd0, 3'd3},
    '{8'h80, 8'h30, 8'h59, 16'h0010, 16'h0020, 1'b1, 3'd1, 3'd4, 1'b1, 1'b1, 1'b0, 2'd0, 3'd4},
    '{8'h88, 8'h02, 8'h59, 16'h0010, 16'h0020, 1'b1, 3'd1, 3'd1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd4},
    '{8'h8C, 8'h00, 8'h6D, 16'h0010, 16'h0020, 1'b1, 3'd1, 3'd1, 1'b1, 1'b0, 1'b0, 2'd1, 3'd5},
    '{8'hC8, 8'h02, 8'h90, 16'h0010, 16'h0020, 1'b1, 3'd2, 3'd1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd6},
    '{8'h42, 8'h04, 8'hD0, 16'h0010, 16'h0020, 1'b1, 3'd3, 3'd1, 1'b0, 1'b0, 1'b0, 2'd2, 3'd7},
    '{8'hC8, 8'h04, 8'h05, 16'h0010, 16'h0020, 1'b1, 3'd2, 3'd1, 1'b1, 1'b0, 1'b0, 2'd0, 3'd1},
    '{8'h41, 8'h00, 8'h0D, 16'h0010, 16'h0020, 1'b1, 3'd3, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0, 3'd2},
    '{8'h03, 8'h00, 8'h0D, 16'h0030, 16'h0050, 1'b1, 3'd4, 3'd1, 1'b0, 1'b0, 1'b1, 2'd2, 3'd2},
    '{8'h00, 8'h40, 8'h0D, 16'h0010, 16'h0020, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{8'h06, 8'h00, 8'h0D, 16'h0010, 16'h0020, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{8'h00, 8'h00, 8'h33, 16'h0010, 16'h0020, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{8'h00, 8'h00, 8'h00, 16'h0040, 16'h0000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{8'hC2, 8'h04, 8'h50, 16'h0010, 16'h0020, 1'b1, 3'd2, 3'd1, 1'b1, 1'b1, 1'b0, 2'd2, 3'd3},
    '{8'h84, 8'h00, 8'h0D, 16'h0010, 16'h0000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic writeCtl(input logic [7:0] d);
    @(negedge clk);
    ctlWrEn   = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWrEn   = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    engineDone = 1'b1;
    @(negedge clk);
    engineDone = 1'b0;
  endtask

  task automatic setStatic(input vecT v);
    modeByte    = v.mode;
    extModeByte = v.ext;
    ropByte     = v.rop;
    srcPitchIn  = v.sp;
    dstPitchIn  = v.dp;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset busy", {31'b0, busy}, 0);
    chk("R11 reset launch", {31'b0, launch}, 0);
    chk("R1 reset strobe", {31'b0, blitReset}, 0);
    chk("R1 reset bpp", {29'b0, bytesPerPix}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vecT v;
      logic [15:0] eSp, eDp;
      v = VEC[i];
      setStatic(v);
      writeCtl(8'h00);
      writeCtl(8'h01);
      eSp = !v.ok ? 16'h0 : (v.back ? 16'(-v.sp) : v.sp);
      eDp = !v.ok ? 16'h0 : (v.back ? 16'(-v.dp) : v.dp);
      chk($sformatf("R2 R9 R10 R3 R4 launch vec%0d", i), {31'b0, launch}, {31'b0, v.ok});
      chk($sformatf("R3 R4 R9 R10 abort strobe vec%0d", i), {31'b0, blitReset}, {31'b0, !v.ok});
      chk($sformatf("R11 busy vec%0d", i), {31'b0, busy}, {31'b0, v.ok});
      chk($sformatf("R5 R6 R7 opClass vec%0d", i), {29'b0, opClass}, {29'b0, v.op});
      chk($sformatf("R3 bpp vec%0d", i), {29'b0, bytesPerPix}, {29'b0, v.bpp});
      chk($sformatf("R5 R6 R7 colours vec%0d", i), {30'b0, loadFg, loadBg}, {30'b0, v.fg, v.bg});
      chk($sformatf("R8 backward vec%0d", i), {31'b0, backward}, {31'b0, v.back});
      chk($sformatf("R9 path vec%0d", i), {30'b0, dataPath}, {30'b0, v.path});
      chk($sformatf("R10 ropIndex vec%0d", i), {29'b0, ropIndex}, {29'b0, v.idx});
      chk($sformatf("R8 pitches vec%0d", i), {srcPitch, dstPitch}, {eSp, eDp});
      @(negedge clk);
      chk($sformatf("R11 launch one cycle vec%0d", i), {30'b0, launch, blitReset}, 0);
      if (v.ok) begin
        pulseDone();
        chk($sformatf("R11 done clears busy vec%0d", i), {31'b0, busy}, 0);
      end
    end

    // R12: start held high, reset bit raised: no edge
    setStatic(VEC[0]);
    writeCtl(8'h00);
    writeCtl(8'h01);
    chk("R11 launch for R12 setup", {31'b0, launch}, 1);
    writeCtl(8'h05);
    chk("R12 no edge no strobe", {30'b0, launch, blitReset}, 0);
    chk("R12 busy kept", {31'b0, busy}, 1);
    chk("R12 fields kept", {29'b0, bytesPerPix}, 1);
    repeat (4) @(negedge clk);
    chk("R11 busy holds without done", {31'b0, busy}, 1);
    writeCtl(8'h04);
    chk("R12 reset bit held no strobe", {31'b0, blitReset}, 0);
    // R1: reset release
    writeCtl(8'h00);
    chk("R1 reset strobe", {31'b0, blitReset}, 1);
    chk("R1 busy cleared", {31'b0, busy}, 0);
    chk("R1 fields cleared", {29'b0, bytesPerPix}, 0);
    chk("R1 pitch cleared", {16'b0, srcPitch}, 0);
    @(negedge clk);
    chk("R1 reset one cycle", {31'b0, blitReset}, 0);

    // R2: both edges in one write, reset wins
    writeCtl(8'h04);
    writeCtl(8'h01);
    chk("R2 priority reset", {31'b0, blitReset}, 1);
    chk("R2 priority no launch", {31'b0, launch}, 0);
    chk("R2 priority not busy", {31'b0, busy}, 0);

    // R12: data with no write strobe
    writeCtl(8'h00);
    @(negedge clk);
    ctlWrData = 8'h01;
    @(negedge clk);
    chk("R12 no write no launch", {30'b0, launch, blitReset}, 0);
    chk("R12 no write busy", {31'b0, busy}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule